// File: doc/BRIEF.md
# FSK Frame Sequencer with Seamless Reload

The block transmits a frame of frequency-shift-keyed symbols as a stream of 8-bit tone codes for a downstream synthesiser. A frame has a 22-bit data word and two 8-bit tone words, a "mark" tone and a "space" tone. Each data bit occupies one symbol period of `SYM_CYCLES` clocks. During that period the output carries the mark tone when the bit is 1 and the space tone when it is 0. Bit 0 goes out first.

The next frame is delivered on a valid/ready port into a one-deep staging register. The staged frame replaces the active frame on the same clock edge that ends the last symbol, so the output stream has no gap between frames. Each frame boundary raises a one-cycle completion strobe. If nothing was staged at the boundary, the active frame plays again and a one-cycle underrun strobe goes out alongside the completion strobe.

When the block has no active frame, for example after reset, a staged frame is promoted on the next edge, so transmission does not wait for a boundary. Dropping the enable forces the output to zero and restarts the symbol timing. Raising it again restarts the active frame from bit 0.

Top module: `fsk_frame_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high, the next edge sets `tone_out` to 0, `frame_done` and `underrun` to 0 and `in_ready` to 1, and discards any active or staged frame. After reset, with `en` high and no frame supplied, `tone_out` stays 0.
- R2: Each data bit is held on the output for exactly `SYM_CYCLES` clocks. Bits are sent in index order 0 to `DATA_W-1`, and the index then wraps to 0.
- R3: While a data bit is being sent, `tone_out` equals `in_mark` of the frame if the bit is 1 and `in_space` if it is 0. The data word sits in `in_data`, where bit i is symbol i.
- R4: A frame is staged on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the staged frame is promoted. While `in_ready` is 0, `in_valid` and the input words are ignored.
- R5: A staged frame becomes active on the edge that ends the last symbol period of the current frame. Its bit 0 appears on `tone_out` in the very next cycle, with no idle or zero cycle in between.
- R6: If nothing is staged when a frame ends, the same frame plays again from bit 0 and `underrun` is 1 for exactly the one cycle in which `frame_done` is 1.
- R7: `frame_done` is 1 for exactly one cycle per completed frame, in the cycle that shows the last output sample of the frame's final symbol.
- R8: One edge after `en` is low, `tone_out` is 0 and no strobe is raised. After `en` returns high, the active frame restarts from bit 0 with full-length symbols.
- R9: When no frame is active, a staged frame becomes active on the following edge. With `en` high, bit 0 of that frame appears on `tone_out` two cycles after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmit enable |
| in_valid | input | 1 | Frame offered on the input words |
| in_ready | output | 1 | Staging register is free |
| in_data | input | DATA_W | Symbol bits, bit 0 sent first |
| in_mark | input | TONE_W | Tone code used for 1 bits |
| in_space | input | TONE_W | Tone code used for 0 bits |
| tone_out | output | TONE_W | Registered tone code |
| frame_done | output | 1 | One-cycle strobe at each frame end |
| underrun | output | 1 | One-cycle strobe when a frame end found nothing staged |

## Verification
`tone_out` is registered one stage behind the symbol counters. When the first edge with `en` high and an active frame occurs, bit 0 is visible from the sample that follows it, and bit `b` is visible for samples `b*SYM_CYCLES` to `b*SYM_CYCLES+SYM_CYCLES-1` counted from that point. `frame_done` and `underrun` are visible in the same sample as the last output sample of a frame, and the new frame's bit 0 appears in the next sample. `in_ready` falls in the sample after the accepting edge and rises in the sample after the promotion edge. The bench drives inputs and samples every output on the falling clock edge. It walks one expected value per sample against a counter restarted at each enable or frame start, so every comparison lands in exactly the cycle these latencies give.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;
  // Whether an active frame exists in the working registers.
  typedef enum logic {
    SEQ_EMPTY  = 1'b0,
    SEQ_LOADED = 1'b1
  } seq_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fsk_sym_timer.sv
module fsk_sym_timer #(
  parameter int SYM_CYCLES = 1024,
  parameter int NUM_SYMS   = 22,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [IDX_W-1:0] sym_idx,
  output logic             sym_last,
  output logic             frame_last
);
  localparam int CYC_W = fsk_seq_pkg::idx_bits(SYM_CYCLES);

  logic [CYC_W-1:0] cyc_q;

  assign sym_last   = run && (cyc_q == CYC_W'(SYM_CYCLES - 1));
  assign frame_last = sym_last && (sym_idx == IDX_W'(NUM_SYMS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_q   <= '0;
      sym_idx <= '0;
    end else if (sym_last) begin
      cyc_q   <= '0;
      sym_idx <= frame_last ? '0 : sym_idx + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_frame_buf.sv
module fsk_frame_buf #(
  parameter int FRAME_W = 38
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               take,
  output logic               full,
  output logic [FRAME_W-1:0] shd_frame
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // Payload register without reset: only read while full is set.
  always_ff @(posedge clk) begin
    if (in_valid && !full) shd_frame <= in_frame;
  end
endmodule

// File: rtl/fsk_tone_sel.sv
module fsk_tone_sel #(
  parameter int DATA_W = 22,
  parameter int TONE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] data,
  input  logic [TONE_W-1:0] mark,
  input  logic [TONE_W-1:0] space,
  input  logic [IDX_W-1:0]  idx,
  output logic [TONE_W-1:0] tone_out
);
  always_ff @(posedge clk) begin
    if (rst || !run) tone_out <= '0;
    else             tone_out <= data[idx] ? mark : space;
  end
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq #(
  parameter int DATA_W     = 22,
  parameter int TONE_W     = 8,
  parameter int SYM_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TONE_W-1:0] in_mark,
  input  logic [TONE_W-1:0] in_space,
  output logic [TONE_W-1:0] tone_out,
  output logic              frame_done,
  output logic              underrun
);
  import fsk_seq_pkg::*;

  localparam int IDX_W   = idx_bits(DATA_W);
  localparam int FRAME_W = DATA_W + 2 * TONE_W;

  seq_state_e         state_q;
  logic               shd_full, take_shd, run;
  logic               frame_last, sym_last;
  logic [IDX_W-1:0]   sym_idx;
  logic [FRAME_W-1:0] shd_frame, work_q;

  assign run      = en && (state_q == SEQ_LOADED);
  assign take_shd = shd_full && ((state_q == SEQ_EMPTY) || frame_last);

  fsk_frame_buf #(.FRAME_W(FRAME_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_frame  ({in_data, in_mark, in_space}),
    .take      (take_shd),
    .full      (shd_full),
    .shd_frame (shd_frame)
  );

  fsk_sym_timer #(
    .SYM_CYCLES (SYM_CYCLES),
    .NUM_SYMS   (DATA_W),
    .IDX_W      (IDX_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .sym_idx    (sym_idx),
    .sym_last   (sym_last),
    .frame_last (frame_last)
  );

  always_ff @(posedge clk) begin
    if (take_shd) work_q <= shd_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_EMPTY;
      frame_done <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      frame_done <= frame_last;
      underrun   <= frame_last && !shd_full;
      if (state_q == SEQ_EMPTY && shd_full) state_q <= SEQ_LOADED;
    end
  end

  fsk_tone_sel #(
    .DATA_W (DATA_W),
    .TONE_W (TONE_W),
    .IDX_W  (IDX_W)
  ) u_sel (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .data     (work_q[FRAME_W-1 -: DATA_W]),
    .mark     (work_q[2*TONE_W-1 -: TONE_W]),
    .space    (work_q[TONE_W-1:0]),
    .idx      (sym_idx),
    .tone_out (tone_out)
  );
endmodule

// File: rtl/fsk_frame_seq_chk.sv
module fsk_frame_seq_chk #(
  parameter int TONE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              in_valid,
  input logic              in_ready,
  input logic [TONE_W-1:0] tone_out,
  input logic              frame_done,
  input logic              underrun
);
  // R4: an accepted frame closes the port on the next cycle
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7: completion strobe never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R6: underrun only accompanies a frame end
  a_r6_underrun_at_end: assert property (@(posedge clk) disable iff (rst)
    underrun |-> frame_done);

  // R8: output silent one edge after enable is low
  a_r8_silent_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tone_out == '0 && !frame_done));
endmodule

bind fsk_frame_seq fsk_frame_seq_chk #(.TONE_W(TONE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .tone_out   (tone_out),
  .frame_done (frame_done),
  .underrun   (underrun)
);

// File: tb/fsk_frame_seq_tb.sv
module fsk_frame_seq_tb;
  localparam int DW  = 22;
  localparam int TW  = 8;
  localparam int S   = 4;
  localparam int FCY = DW * S;
  localparam int FW  = DW + 2 * TW;
  localparam int NF  = 4;

  // Frame vectors {data, mark, space} and the expected underrun at their end.
  localparam logic [FW-1:0] FRAMES [NF] = '{
    {22'h3C2ABA, 8'h88, 8'hE8},
    {22'h2B5555, 8'hAA, 8'hF0},
    {22'h000001, 8'h11, 8'h22},
    {22'h2AAAAA, 8'h5A, 8'hA5}
  };
  localparam bit EXP_UNDER [NF] = '{1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst, en, in_valid, in_ready, frame_done, underrun;
  logic [DW-1:0] in_data;
  logic [TW-1:0] in_mark, in_space, tone_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fsk_frame_seq #(.DATA_W(DW), .TONE_W(TW), .SYM_CYCLES(S)) u_dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .in_space(in_space),
    .tone_out(tone_out), .frame_done(frame_done), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [FW-1:0] fr);
    in_valid = v;
    {in_data, in_mark, in_space} = fr;
  endtask

  function automatic logic [TW-1:0] tone_at(input logic [FW-1:0] fr, input int k);
    return fr[2*TW + (k / S)] ? fr[2*TW-1 -: TW] : fr[TW-1:0];
  endfunction

  // Walks one frame sample by sample; optionally stages a frame at k==5
  // and offers a frame that must be ignored at k==10.
  task automatic play(input logic [FW-1:0] fr, input bit exp_under, input bit first,
                      input bit do_push, input logic [FW-1:0] nxt, input bit bogus);
    for (int k = 0; k < FCY; k++) begin
      @(negedge clk);
      if (k == 0 && !first) chk("R5", tone_out, tone_at(fr, k));
      else if (k % S == 0)  chk("R2", tone_out, tone_at(fr, k));
      else                  chk("R3", tone_out, tone_at(fr, k));
      chk("R7", frame_done, (k == FCY - 1));
      chk("R6", underrun, (k == FCY - 1) && exp_under);
      if (do_push && k == 4) chk("R4", in_ready, 1);
      if (do_push && k == 7) chk("R4", in_ready, 0);
      if (do_push && k == 5)     drive(1'b1, nxt);
      else if (bogus && k == 10) drive(1'b1, {22'h3FFFFF, 8'hFF, 8'hFF});
      else                       drive(1'b0, '0);
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; drive(1'b0, '0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", tone_out, 0);
    chk("R1", in_ready, 1);
    chk("R1", {frame_done, underrun}, 0);

    // Stage frame 0 with enable low: promoted on the next edge (R9)
    drive(1'b1, FRAMES[0]);
    @(negedge clk); drive(1'b0, '0);
    chk("R4", in_ready, 0);
    @(negedge clk);
    chk("R9", in_ready, 1);
    drive(1'b1, FRAMES[1]);
    @(negedge clk); drive(1'b0, '0);
    chk("R4", in_ready, 0);
    chk("R8", tone_out, 0);
    en = 1'b1;

    // Vector walk: frames back to back, last one underruns and repeats
    play(FRAMES[0], EXP_UNDER[0], 1'b1, 1'b0, '0, 1'b1);
    for (int f = 1; f < NF; f++)
      play(FRAMES[f], EXP_UNDER[f], 1'b0, (f + 1 < NF), FRAMES[(f + 1) % NF], 1'b0);
    play(FRAMES[NF-1], 1'b1, 1'b0, 1'b0, '0, 1'b0);

    // R8: enable low mid-stream, then restart from bit 0
    en = 1'b0;
    @(negedge clk);
    chk("R8", tone_out, 0);
    chk("R8", {frame_done, underrun}, 0);
    @(negedge clk);
    chk("R8", tone_out, 0);
    en = 1'b1;
    for (int k = 0; k < 2 * S + 1; k++) begin
      @(negedge clk);
      chk("R8", tone_out, tone_at(FRAMES[3], k));
    end

    // R1: reset mid-stream discards the active frame
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", tone_out, 0);
    chk("R1", in_ready, 1);
    repeat (S + 2) @(negedge clk);
    chk("R1", tone_out, 0);
    chk("R1", frame_done, 0);

    // R9: first frame with enable already high
    drive(1'b1, FRAMES[0]);
    @(negedge clk); drive(1'b0, '0);
    @(negedge clk);
    chk("R9", tone_out, 0);
    for (int k = 0; k < 2 * S; k++) begin
      @(negedge clk);
      chk("R9", tone_out, tone_at(FRAMES[0], k));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule